// File: doc/BRIEF.md
# Strobed Parallel Port Controller

This block gives a processor three byte-wide parallel ports, named A, B and C, behind a small register interface. The interface has an active-low chip select, active-low read and write strobes, and a two-bit register address. Each access lasts one clock cycle: a write is taken in any cycle where chip select and write are both low, and a read is taken in any cycle where chip select and read are both low. Read data is combinational and only valid during that cycle. The interface has no back-pressure. Every access completes in the cycle it is presented, and no access can be refused or stalled.

A control word written to the control address has one of two meanings. If its top bit is 1, it reconfigures the ports. If its top bit is 0, it sets or clears a single port C bit. Ports A and B each work in one of two ways:
- **Plain mode.** The port is a simple latched output or a direct pin input.
- **Strobed mode.** The port exchanges bytes with a peripheral through a handshake. Fixed port C lines carry the strobe or acknowledge, the buffer-full flag and the interrupt request.

Port C lines not taken by a handshake act as two independent 4-bit halves. Pads are modelled as separate input, output and per-bit output-enable vectors.

Top module: `ppc_port_ctrl`

## Requirements
- R1: After reset the control register reads 0x9B, and the output enables of all three ports are zero.
- R2: Address 0 selects port A, 1 selects port B, 2 selects port C and 3 selects the control register. A control read always returns bit 7 as 1.
- R3: A control write with bit 7 = 1 sets the configuration and clears all output latches, buffer-full flags, interrupt requests and interrupt enables. The fields are:
  - bits 6..5: port A mode; any nonzero value selects strobed mode.
  - bit 4: port A direction.
  - bit 3: port C upper-half direction.
  - bit 2: port B strobed mode.
  - bit 1: port B direction.
  - bit 0: port C lower-half direction.
  - For every direction bit, 1 means input.
- R4: In plain mode an output port drives its latch with all enables set, and an input port reads its pins. The upper half of port C follows bit 3 and the lower half follows bit 0, each independently.
- R5: A control write with bit 7 = 0 copies bit 0 into the port C latch bit indexed by bits 3..1. It leaves the port A and port B outputs unchanged.
- R6: In strobed input mode a low strobe latches the port pins and sets buffer-full on the next cycle. For port A the strobe is PC4 and buffer-full is PC5; for port B they are PC2 and PC1. A port read returns the latched byte.
- R7: In strobed input mode the interrupt request goes high one cycle after a cycle in which the strobe is high, buffer-full is set and interrupt-enable is set. The request is on PC3 for port A and PC0 for port B. A port read clears both buffer-full and the request on the next cycle.
- R8: In strobed output mode a port write drives the active-low output-buffer-full line low on the next cycle, and a low acknowledge returns it high. For port A that line is PC7 and the acknowledge is PC6; for port B they are PC1 and PC2.
- R9: In strobed output mode the interrupt request goes high one cycle after a cycle in which output-buffer-full is high, the acknowledge is high and interrupt-enable is set. A port write clears it.
- R10: Interrupt enables are set or cleared by bit set/reset words at these indices:
  - port A input: 4;
  - port A output: 6;
  - port B: 2.
  
  A port C read returns each enable at the bit of the handshake input line it shares. While an enable is clear, no request is raised.
- R11: If a strobe falls in the same cycle as a port read, the read returns the old byte, the new byte is latched and buffer-full stays set. If an acknowledge falls in the same cycle as a port write, output-buffer-full stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, zero when no read is in progress |
| pa_in | input | 8 | Port A pins in |
| pa_out | output | 8 | Port A pins out |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pins in |
| pb_out | output | 8 | Port B pins out |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pins in, including strobe and acknowledge lines |
| pc_out | output | 8 | Port C pins out, including handshake flags |
| pc_oe | output | 8 | Port C output enables |

## Verification
Two pairs of events can land in the same cycle, and each pair is exercised on purpose.

The first pair is a peripheral strobe and a processor read of the same port. The bench drives the strobe low in the exact cycle in which chip select and read are low. The scoreboard expects the byte latched earlier, and a follow-up read expects the byte taken during the collision. Buffer-full is checked to be still high between the two reads.

The second pair is an acknowledge and a processor write on a strobed output port. They are driven together, and the bench checks that output-buffer-full stays low and the new byte appears on the pins.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
  localparam int PW = 8;
  localparam logic [7:0] RESET_WORD = 8'h9B;

  localparam logic [1:0] ADR_A   = 2'd0;
  localparam logic [1:0] ADR_B   = 2'd1;
  localparam logic [1:0] ADR_C   = 2'd2;
  localparam logic [1:0] ADR_CTL = 2'd3;

  // port C line assignment for handshakes (decoded by peripherals)
  localparam int PC_INTR_B = 0;
  localparam int PC_BUF_B  = 1;
  localparam int PC_HS_B   = 2;
  localparam int PC_INTR_A = 3;
  localparam int PC_STB_A  = 4;
  localparam int PC_IBF_A  = 5;
  localparam int PC_ACK_A  = 6;
  localparam int PC_OBF_A  = 7;

  typedef enum logic [1:0] {
    LR_GPIO   = 2'd0,
    LR_HS_OUT = 2'd1,
    LR_HS_IN  = 2'd2
  } line_role_e;
endpackage

// File: rtl/ppc_ctrl.sv
module ppc_ctrl
  import ppc_pkg::*;
#(
  parameter logic [7:0] RST_WORD = RESET_WORD
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_hit,
  input  logic [1:0]    addr,
  input  logic [PW-1:0] wdata,
  output logic [6:0]    cfg_bits,
  output logic [PW-1:0] pc_latch,
  output logic          inte_a,
  output logic          inte_b,
  output logic          mode_clr
);
  logic       bsr;
  logic [2:0] idx;
  logic       a_strobed, a_in, b_strobed;

  assign mode_clr   = wr_hit && (addr == ADR_CTL) && wdata[7];
  assign bsr        = wr_hit && (addr == ADR_CTL) && !wdata[7];
  assign idx        = wdata[3:1];
  assign a_strobed  = |cfg_bits[6:5];
  assign a_in       = cfg_bits[4];
  assign b_strobed  = cfg_bits[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_bits <= RST_WORD[6:0];
      pc_latch <= '0;
      inte_a   <= 1'b0;
      inte_b   <= 1'b0;
    end else if (mode_clr) begin
      cfg_bits <= wdata[6:0];
      pc_latch <= '0;
      inte_a   <= 1'b0;
      inte_b   <= 1'b0;
    end else if (bsr) begin
      pc_latch[idx] <= wdata[0];
      if (a_strobed && ((a_in && idx == 3'(PC_STB_A)) || (!a_in && idx == 3'(PC_ACK_A))))
        inte_a <= wdata[0];
      if (b_strobed && idx == 3'(PC_HS_B))
        inte_b <= wdata[0];
    end else if (wr_hit && addr == ADR_C) begin
      pc_latch <= wdata;
    end
  end
endmodule

// File: rtl/ppc_hs_chan.sv
module ppc_hs_chan #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         strobed,
  input  logic         dir_in,
  input  logic [W-1:0] pins,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         rd,
  input  logic         hs_n,
  input  logic         inte,
  output logic [W-1:0] out_q,
  output logic [W-1:0] rd_data,
  output logic         full,
  output logic         intr
);
  logic [W-1:0] in_q;
  logic         s_in, s_out;

  assign s_in  = strobed && dir_in;
  assign s_out = strobed && !dir_in;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      out_q <= '0;
      in_q  <= '0;
      full  <= 1'b0;
      intr  <= 1'b0;
    end else begin
      if (wr) out_q <= wdata;
      if (s_in && !hs_n) in_q <= pins;
      if (s_in) begin
        if (!hs_n)   full <= 1'b1;
        else if (rd) full <= 1'b0;
        intr <= full && hs_n && inte && !rd;
      end else if (s_out) begin
        if (wr)         full <= 1'b1;
        else if (!hs_n) full <= 1'b0;
        intr <= !full && hs_n && inte && !wr;
      end else begin
        full <= 1'b0;
        intr <= 1'b0;
      end
    end
  end

  assign rd_data = s_in ? in_q : (dir_in ? pins : out_q);
endmodule

// File: rtl/ppc_portc.sv
module ppc_portc
  import ppc_pkg::*;
(
  input  logic [6:0]    cfg_bits,
  input  logic [PW-1:0] pc_latch,
  input  logic [PW-1:0] pc_in,
  input  logic          intr_a,
  input  logic          full_a,
  input  logic          inte_a,
  input  logic          intr_b,
  input  logic          full_b,
  input  logic          inte_b,
  output logic [PW-1:0] pc_out,
  output logic [PW-1:0] pc_oe,
  output logic [PW-1:0] pc_rd
);
  line_role_e    role [PW];
  logic [PW-1:0] hs_val;
  logic          a_strobed, a_in, c_hi_in, b_strobed, b_in, c_lo_in;

  assign a_strobed = |cfg_bits[6:5];
  assign a_in      = cfg_bits[4];
  assign c_hi_in   = cfg_bits[3];
  assign b_strobed = cfg_bits[2];
  assign b_in      = cfg_bits[1];
  assign c_lo_in   = cfg_bits[0];

  always_comb begin
    for (int i = 0; i < PW; i++) role[i] = LR_GPIO;
    hs_val = '0;
    if (a_strobed) begin
      role[PC_INTR_A]   = LR_HS_OUT;
      hs_val[PC_INTR_A] = intr_a;
      if (a_in) begin
        role[PC_STB_A]   = LR_HS_IN;
        role[PC_IBF_A]   = LR_HS_OUT;
        hs_val[PC_IBF_A] = full_a;
      end else begin
        role[PC_ACK_A]   = LR_HS_IN;
        role[PC_OBF_A]   = LR_HS_OUT;
        hs_val[PC_OBF_A] = !full_a;
      end
    end
    if (b_strobed) begin
      role[PC_INTR_B]   = LR_HS_OUT;
      hs_val[PC_INTR_B] = intr_b;
      role[PC_BUF_B]    = LR_HS_OUT;
      hs_val[PC_BUF_B]  = b_in ? full_b : !full_b;
      role[PC_HS_B]     = LR_HS_IN;
    end
  end

  always_comb begin
    for (int i = 0; i < PW; i++) begin
      logic g_in;
      g_in = (i >= PW/2) ? c_hi_in : c_lo_in;
      case (role[i])
        LR_HS_OUT: begin
          pc_oe[i]  = 1'b1;
          pc_out[i] = hs_val[i];
          pc_rd[i]  = hs_val[i];
        end
        LR_HS_IN: begin
          pc_oe[i]  = 1'b0;
          pc_out[i] = 1'b0;
          pc_rd[i]  = (i < PW/2) ? inte_b : inte_a;
        end
        default: begin
          pc_oe[i]  = !g_in;
          pc_out[i] = g_in ? 1'b0 : pc_latch[i];
          pc_rd[i]  = g_in ? pc_in[i] : pc_latch[i];
        end
      endcase
    end
  end
endmodule

// File: rtl/ppc_port_ctrl.sv
module ppc_port_ctrl
  import ppc_pkg::*;
#(
  parameter logic [7:0] RST_WORD = RESET_WORD
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [1:0]    addr,
  input  logic [PW-1:0] wdata,
  output logic [PW-1:0] rdata,
  input  logic [PW-1:0] pa_in,
  output logic [PW-1:0] pa_out,
  output logic [PW-1:0] pa_oe,
  input  logic [PW-1:0] pb_in,
  output logic [PW-1:0] pb_out,
  output logic [PW-1:0] pb_oe,
  input  logic [PW-1:0] pc_in,
  output logic [PW-1:0] pc_out,
  output logic [PW-1:0] pc_oe
);
  logic          wr_hit, rd_hit, mode_clr;
  logic [6:0]    cfg_bits;
  logic [PW-1:0] pc_latch, a_rd, b_rd, pc_rd;
  logic          inte_a, inte_b, full_a, full_b, intr_a, intr_b;
  logic          hs_a_n;

  assign wr_hit = !cs_n && !wr_n;
  assign rd_hit = !cs_n && !rd_n;
  assign hs_a_n = cfg_bits[4] ? pc_in[PC_STB_A] : pc_in[PC_ACK_A];

  ppc_ctrl #(.RST_WORD(RST_WORD)) ctrl_i (
    .clk(clk), .rst(rst), .wr_hit(wr_hit), .addr(addr), .wdata(wdata),
    .cfg_bits(cfg_bits), .pc_latch(pc_latch), .inte_a(inte_a), .inte_b(inte_b),
    .mode_clr(mode_clr)
  );

  ppc_hs_chan #(.W(PW)) chan_a_i (
    .clk(clk), .rst(rst), .clr(mode_clr), .strobed(|cfg_bits[6:5]),
    .dir_in(cfg_bits[4]), .pins(pa_in), .wr(wr_hit && addr == ADR_A),
    .wdata(wdata), .rd(rd_hit && addr == ADR_A), .hs_n(hs_a_n), .inte(inte_a),
    .out_q(pa_out), .rd_data(a_rd), .full(full_a), .intr(intr_a)
  );

  ppc_hs_chan #(.W(PW)) chan_b_i (
    .clk(clk), .rst(rst), .clr(mode_clr), .strobed(cfg_bits[2]),
    .dir_in(cfg_bits[1]), .pins(pb_in), .wr(wr_hit && addr == ADR_B),
    .wdata(wdata), .rd(rd_hit && addr == ADR_B), .hs_n(pc_in[PC_HS_B]),
    .inte(inte_b), .out_q(pb_out), .rd_data(b_rd), .full(full_b), .intr(intr_b)
  );

  ppc_portc portc_i (
    .cfg_bits(cfg_bits), .pc_latch(pc_latch), .pc_in(pc_in),
    .intr_a(intr_a), .full_a(full_a), .inte_a(inte_a),
    .intr_b(intr_b), .full_b(full_b), .inte_b(inte_b),
    .pc_out(pc_out), .pc_oe(pc_oe), .pc_rd(pc_rd)
  );

  assign pa_oe = {PW{!cfg_bits[4]}};
  assign pb_oe = {PW{!cfg_bits[1]}};

  always_comb begin
    rdata = '0;
    if (rd_hit) begin
      case (addr)
        ADR_A:   rdata = a_rd;
        ADR_B:   rdata = b_rd;
        ADR_C:   rdata = pc_rd;
        default: rdata = {1'b1, cfg_bits};
      endcase
    end
  end
endmodule

// File: rtl/ppc_checker.sv
module ppc_checker (
  input logic       clk,
  input logic       rst,
  input logic       cs_n,
  input logic       rd_n,
  input logic       wr_n,
  input logic [1:0] addr,
  input logic       wd7,
  input logic       rd7,
  input logic [7:0] pa_out,
  input logic [7:0] pb_out,
  input logic       stb_a_n,
  input logic       intr_a,
  input logic       ibf_a,
  input logic       obf_a_n,
  input logic [2:0] a_cfg
);
  logic wr_ctl, rd_any, a_sin, a_sout;
  assign wr_ctl = !cs_n && !wr_n && addr == 2'd3;
  assign rd_any = !cs_n && !rd_n;
  assign a_sin  = (a_cfg[2:1] != 2'b00) && a_cfg[0];
  assign a_sout = (a_cfg[2:1] != 2'b00) && !a_cfg[0];

  assert_ctl_msb_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_any && addr == 2'd3) |-> rd7);

  assert_bsr_keeps_ab_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_ctl && !wd7) |=> ($stable(pa_out) && $stable(pb_out)));

  assert_mode_clears_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_ctl && wd7) |=> (pa_out == 8'h00 && pb_out == 8'h00));

  assert_stb_sets_ibf_R6: assert property (@(posedge clk) disable iff (rst)
    (a_sin && !stb_a_n && !(wr_ctl && wd7)) |=> ibf_a);

  assert_wr_drops_obf_R8: assert property (@(posedge clk) disable iff (rst)
    (a_sout && !cs_n && !wr_n && addr == 2'd0) |=> !obf_a_n);

  assert_read_clears_intr_R7: assert property (@(posedge clk) disable iff (rst)
    (a_sin && rd_any && wr_n && addr == 2'd0) |=> !intr_a);
endmodule

bind ppc_port_ctrl ppc_checker chk_i (
  .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
  .wd7(wdata[7]), .rd7(rdata[7]), .pa_out(pa_out), .pb_out(pb_out),
  .stb_a_n(pc_in[4]), .intr_a(pc_out[3]), .ibf_a(pc_out[5]),
  .obf_a_n(pc_out[7]), .a_cfg(cfg_bits[6:4])
);

// File: tb/ppc_port_ctrl_tb.sv
module ppc_port_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [7:0] pa_in = 8'h00, pa_out, pa_oe;
  logic [7:0] pb_in = 8'h00, pb_out, pb_oe;
  logic [7:0] pc_in = 8'hFF, pc_out, pc_oe;
  logic [7:0] pc_idle = 8'hFF;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ppc_port_ctrl dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .pc_in(pc_in),
    .pc_out(pc_out), .pc_oe(pc_oe)
  );

  task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  // scoreboard monitor: compares read data mid-cycle
  always @(negedge clk) begin
    if (!cs_n && !rd_n) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL scoreboard: got %02h expected none", rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rdata, e, t);
      end
    end
  end

  task automatic bus_op(input bit do_rd, input bit do_wr, input logic [1:0] a,
                        input logic [7:0] d, input logic [7:0] stb_mask,
                        input logic [7:0] exp, input string tag);
    @(posedge clk); #2;
    cs_n  = !(do_rd || do_wr);
    rd_n  = !do_rd;
    wr_n  = !do_wr;
    addr  = a;
    wdata = d;
    pc_in = pc_idle & ~stb_mask;
    if (do_rd) begin
      exp_q.push_back(exp);
      tag_q.push_back(tag);
    end
    @(posedge clk); #2;
    cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    pc_in = pc_idle;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_op(1'b0, 1'b1, a, d, 8'h00, 8'h00, "");
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
    bus_op(1'b1, 1'b0, a, 8'h00, 8'h00, e, tag);
  endtask

  task automatic strobe(input logic [7:0] m);
    bus_op(1'b0, 1'b0, 2'd0, 8'h00, m, 8'h00, "");
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic next_cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    settle();
    // R1 reset state
    check(pa_oe, 8'h00, "R1 pa_oe");
    check(pb_oe, 8'h00, "R1 pb_oe");
    check(pc_oe, 8'h00, "R1 pc_oe");
    rd(2'd3, 8'h9B, "R1 R2 ctl reset value");

    // R4 plain mode, all outputs
    wr(2'd3, 8'h80);
    wr(2'd0, 8'h5A); settle();
    check(pa_out, 8'h5A, "R4 pa_out");
    check(pa_oe, 8'hFF, "R4 pa_oe");
    rd(2'd0, 8'h5A, "R2 R4 read A latch");
    wr(2'd1, 8'hC3);
    rd(2'd1, 8'hC3, "R2 R4 read B latch");

    // R4 port C halves, R3 clear on mode set
    wr(2'd3, 8'h88); settle();
    check(pa_out, 8'h00, "R3 mode set clears A");
    check(pc_oe, 8'h0F, "R4 pc halves oe");
    pc_idle = 8'h9D; pc_in = pc_idle;
    wr(2'd2, 8'hA5); settle();
    check(pc_out, 8'h05, "R4 pc lower out");
    rd(2'd2, 8'h95, "R4 pc mixed read");

    // R5 bit set/reset
    wr(2'd0, 8'h33);
    wr(2'd3, 8'h07); settle();
    check(pc_out, 8'h0D, "R5 set bit3");
    check(pa_out, 8'h33, "R5 A unchanged");
    wr(2'd3, 8'h00); settle();
    check(pc_out, 8'h0C, "R5 clear bit0");
    pc_idle = 8'hFF; pc_in = pc_idle;

    // R6 R7 R10 strobed input on port A
    wr(2'd3, 8'hB0); settle();
    check(pc_oe, 8'hEF, "R6 A input pc_oe");
    rd(2'd2, 8'h00, "R10 inte clear readback");
    wr(2'd3, 8'h09);
    rd(2'd2, 8'h10, "R10 inte set readback");
    pa_in = 8'h6C;
    strobe(8'h10); settle();
    check({7'd0, pc_out[5]}, 8'h01, "R6 ibf set");
    next_cycle();
    check({7'd0, pc_out[3]}, 8'h01, "R7 intr raised");
    rd(2'd0, 8'h6C, "R6 latched byte");
    settle();
    check({6'd0, pc_out[5], pc_out[3]}, 8'h00, "R7 read clears ibf and intr");
    wr(2'd3, 8'h08);
    pa_in = 8'h11;
    strobe(8'h10); next_cycle();
    check({6'd0, pc_out[5], pc_out[3]}, 8'h02, "R10 no intr when disabled");
    rd(2'd0, 8'h11, "R6 second byte");

    // R11 strobe and read in the same cycle
    pa_in = 8'h22;
    strobe(8'h10);
    pa_in = 8'h44;
    bus_op(1'b1, 1'b0, 2'd0, 8'h00, 8'h10, 8'h22, "R11 read during strobe old byte");
    settle();
    check({7'd0, pc_out[5]}, 8'h01, "R11 ibf kept");
    rd(2'd0, 8'h44, "R11 new byte latched");

    // R8 R9 strobed output on port A
    wr(2'd3, 8'hA0); settle();
    check(pc_oe, 8'hBF, "R8 A output pc_oe");
    check({7'd0, pc_out[7]}, 8'h01, "R8 obf idle high");
    wr(2'd3, 8'h0D);
    wr(2'd0, 8'h99); settle();
    check({7'd0, pc_out[7]}, 8'h00, "R8 write drops obf");
    check(pa_out, 8'h99, "R8 data out");
    strobe(8'h40); settle();
    check({7'd0, pc_out[7]}, 8'h01, "R8 ack raises obf");
    next_cycle();
    check({7'd0, pc_out[3]}, 8'h01, "R9 intr after ack");
    wr(2'd0, 8'h77); settle();
    check({6'd0, pc_out[7], pc_out[3]}, 8'h00, "R9 write clears intr");

    // R11 write and ack in the same cycle
    bus_op(1'b0, 1'b1, 2'd0, 8'h55, 8'h40, 8'h00, ""); settle();
    check({7'd0, pc_out[7]}, 8'h00, "R11 obf stays low");
    check(pa_out, 8'h55, "R11 new data out");

    // R3 R6 R7 port B strobed input
    wr(2'd3, 8'h86); settle();
    check(pa_out, 8'h00, "R3 clear on mode set");
    check(pc_oe, 8'hFB, "R6 B input pc_oe");
    wr(2'd3, 8'h05);
    pb_in = 8'hE1;
    strobe(8'h04); settle();
    check({7'd0, pc_out[1]}, 8'h01, "R6 B ibf");
    next_cycle();
    check({7'd0, pc_out[0]}, 8'h01, "R7 B intr");
    rd(2'd1, 8'hE1, "R6 B latched byte");

    // R3 mode field value 3 is strobed
    wr(2'd3, 8'hE0); settle();
    check(pc_oe, 8'hBF, "R3 mode 11 strobed");
    rd(2'd3, 8'hE0, "R2 ctl readback");

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule